// File: doc/BRIEF.md
# Paired Add/Subtract Arithmetic Unit

This unit takes one pair of operands and produces their sum and their difference (first operand minus second) in the same cycle. Both results come out on separate buses and change together on one clock edge. A mode input selects whether each operand is a single 32-bit word or two independent 16-bit halfword lanes. In lane mode, bits 15:0 form lane 0 and bits 31:16 form lane 1.

A second control input selects saturating arithmetic. When it is set, any signed result that leaves its range is clamped to the nearest limit instead of wrapping. Each result carries a two-bit overflow flag. The flag reports whether the result left its signed range, whether or not saturation was requested, so software can use the wrapping form and still detect overflow.

Top module: `dual_addsub_alu`

## Requirements
- R1: The sum a+b appears on `sum_q` and the difference a−b on `diff_q`, together with their flags, on the first rising clock edge after the operands and controls are presented.
- R2: While `rst_n` is low, `sum_q`, `diff_q`, `sum_ovf_q` and `diff_ovf_q` are all zero.
- R3: With `dual_mode`=0 and `sat_en`=0, results are the 32-bit two's-complement sum and difference taken modulo 2^32.
- R4: With `dual_mode`=1 and `sat_en`=0, each 16-bit lane (lane 0 = bits 15:0, lane 1 = bits 31:16) is computed modulo 2^16, and no carry or borrow passes from lane 0 into lane 1.
- R5: With `dual_mode`=0, flag bit 0 is set when the signed 32-bit result lies outside [−2^31, 2^31−1], and flag bit 1 is always 0.
- R6: With `dual_mode`=1, flag bit i is set when the signed 16-bit result of lane i lies outside [−2^15, 2^15−1].
- R7: With `sat_en`=1, a result above the range maximum becomes 0x7FFF (lane) or 0x7FFFFFFF (word), and a result below the minimum becomes 0x8000 or 0x80000000.
- R8: Overflow flags take the same value for `sat_en`=0 and `sat_en`=1 when the operands are the same.
- R9: When no overflow occurs, `sat_en` has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a | input | 32 | First operand (minuend) |
| b | input | 32 | Second operand (subtrahend) |
| dual_mode | input | 1 | 0: one 32-bit word, 1: two 16-bit lanes |
| sat_en | input | 1 | 1: clamp out-of-range results |
| sum_q | output | 32 | Registered a+b |
| diff_q | output | 32 | Registered a−b |
| sum_ovf_q | output | 2 | Per-lane overflow of the sum |
| diff_ovf_q | output | 2 | Per-lane overflow of the difference |

## Verification
Random operand pairs across all four mode/saturation combinations cover the ordinary range, where most results stay in range. These pairs show whether sum and difference are routed to the right buses. Directed pairs at the signed extremes drive each lane past its maximum and past its minimum separately, so a clamp toward the wrong limit or a wrong flag shows up. Operands of 0x0000FFFF plus 1 in lane mode show whether a carry leaks into lane 1. Each extreme pair is applied with and without saturation, which separates flag generation from clamping.

// File: rtl/dual_addsub_alu.sv
module dual_addsub_alu #(
  parameter int LANE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*LANE_W-1:0]   a,
  input  logic [2*LANE_W-1:0]   b,
  input  logic                  dual_mode,
  input  logic                  sat_en,
  output logic [2*LANE_W-1:0]   sum_q,
  output logic [2*LANE_W-1:0]   diff_q,
  output logic [1:0]            sum_ovf_q,
  output logic [1:0]            diff_ovf_q
);
  localparam int W = 2 * LANE_W;

  logic [1:0][LANE_W:0]   l_sum, l_dif;
  logic [1:0][LANE_W-1:0] l_sum_r, l_dif_r;
  logic [1:0]             l_sum_ov, l_dif_ov;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = a[g*LANE_W +: LANE_W];
    assign lb = b[g*LANE_W +: LANE_W];
    assign l_sum[g] = {la[LANE_W-1], la} + {lb[LANE_W-1], lb};
    assign l_dif[g] = {la[LANE_W-1], la} - {lb[LANE_W-1], lb};
    assign l_sum_ov[g] = l_sum[g][LANE_W] ^ l_sum[g][LANE_W-1];
    assign l_dif_ov[g] = l_dif[g][LANE_W] ^ l_dif[g][LANE_W-1];
    assign l_sum_r[g] = (sat_en && l_sum_ov[g]) ?
        {l_sum[g][LANE_W], {(LANE_W-1){~l_sum[g][LANE_W]}}} : l_sum[g][LANE_W-1:0];
    assign l_dif_r[g] = (sat_en && l_dif_ov[g]) ?
        {l_dif[g][LANE_W], {(LANE_W-1){~l_dif[g][LANE_W]}}} : l_dif[g][LANE_W-1:0];
  end

  logic [W:0]   w_sum, w_dif;
  logic         w_sum_ov, w_dif_ov;
  logic [W-1:0] w_sum_r, w_dif_r;

  assign w_sum = {a[W-1], a} + {b[W-1], b};
  assign w_dif = {a[W-1], a} - {b[W-1], b};
  assign w_sum_ov = w_sum[W] ^ w_sum[W-1];
  assign w_dif_ov = w_dif[W] ^ w_dif[W-1];
  assign w_sum_r = (sat_en && w_sum_ov) ? {w_sum[W], {(W-1){~w_sum[W]}}} : w_sum[W-1:0];
  assign w_dif_r = (sat_en && w_dif_ov) ? {w_dif[W], {(W-1){~w_dif[W]}}} : w_dif[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q      <= '0;
      diff_q     <= '0;
      sum_ovf_q  <= '0;
      diff_ovf_q <= '0;
    end else if (dual_mode) begin
      sum_q      <= {l_sum_r[1], l_sum_r[0]};
      diff_q     <= {l_dif_r[1], l_dif_r[0]};
      sum_ovf_q  <= l_sum_ov;
      diff_ovf_q <= l_dif_ov;
    end else begin
      sum_q      <= w_sum_r;
      diff_q     <= w_dif_r;
      sum_ovf_q  <= {1'b0, w_sum_ov};
      diff_ovf_q <= {1'b0, w_dif_ov};
    end
  end
endmodule

// File: rtl/dual_addsub_alu_chk.sv
module dual_addsub_alu_chk #(
  parameter int LANE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*LANE_W-1:0] a,
  input logic [2*LANE_W-1:0] b,
  input logic                dual_mode,
  input logic                sat_en,
  input logic [2*LANE_W-1:0] sum_q,
  input logic [2*LANE_W-1:0] diff_q,
  input logic [1:0]          sum_ovf_q,
  input logic [1:0]          diff_ovf_q
);
  localparam int W = 2 * LANE_W;
  localparam logic [W-1:0] WMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] WMIN = {1'b1, {(W-1){1'b0}}};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (sum_q == '0 && diff_q == '0 && sum_ovf_q == '0 && diff_ovf_q == '0)); // R2

  AST_WORD_SUM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dual_mode) && !sum_ovf_q[0]) |-> sum_q == $past(a) + $past(b)); // R3

  AST_WORD_DIFF_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dual_mode) && !diff_ovf_q[0]) |-> diff_q == $past(a) - $past(b)); // R1

  AST_WORD_FLAG_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dual_mode)) |-> (!sum_ovf_q[1] && !diff_ovf_q[1])); // R5

  AST_LANE0_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dual_mode) && !sum_ovf_q[0]) |->
      sum_q[LANE_W-1:0] == LANE_W'($past(a[LANE_W-1:0]) + $past(b[LANE_W-1:0]))); // R4

  AST_WORD_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dual_mode) && $past(sat_en) && sum_ovf_q[0]) |->
      (sum_q == WMAX || sum_q == WMIN)); // R7
endmodule

bind dual_addsub_alu dual_addsub_alu_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .dual_mode(dual_mode), .sat_en(sat_en),
  .sum_q(sum_q), .diff_q(diff_q), .sum_ovf_q(sum_ovf_q), .diff_ovf_q(diff_ovf_q)
);

// File: tb/tb_dual_addsub_alu.sv
module tb_dual_addsub_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        dual_mode = 1'b0, sat_en = 1'b0;
  logic [31:0] sum_q, diff_q;
  logic [1:0]  sum_ovf_q, diff_ovf_q;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  dual_addsub_alu dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .dual_mode(dual_mode), .sat_en(sat_en),
    .sum_q(sum_q), .diff_q(diff_q), .sum_ovf_q(sum_ovf_q), .diff_ovf_q(diff_ovf_q)
  );

  function automatic logic [31:0] word_op(input logic [31:0] x, input logic [31:0] y,
                                          input bit sub, input bit sat, output bit ov);
    longint r;
    r = sub ? (longint'($signed(x)) - longint'($signed(y)))
            : (longint'($signed(x)) + longint'($signed(y)));
    ov = (r > 64'sd2147483647) || (r < -64'sd2147483648);
    if (sat && ov) return (r > 0) ? 32'h7FFFFFFF : 32'h80000000;
    return r[31:0];
  endfunction

  function automatic logic [15:0] lane_op(input logic [15:0] x, input logic [15:0] y,
                                          input bit sub, input bit sat, output bit ov);
    int r;
    r = sub ? (int'($signed(x)) - int'($signed(y))) : (int'($signed(x)) + int'($signed(y)));
    ov = (r > 32767) || (r < -32768);
    if (sat && ov) return (r > 0) ? 16'h7FFF : 16'h8000;
    return r[15:0];
  endfunction

  task automatic cmp(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] x, input logic [31:0] y, input bit dm, input bit se,
                     input string req);
    logic [31:0] es, ed;
    logic [1:0]  eso, edo;
    bit o0, o1, p0, p1;
    @(negedge clk);
    a = x; b = y; dual_mode = dm; sat_en = se;
    if (dm) begin
      es[15:0]  = lane_op(x[15:0], y[15:0], 1'b0, se, o0);
      es[31:16] = lane_op(x[31:16], y[31:16], 1'b0, se, o1);
      ed[15:0]  = lane_op(x[15:0], y[15:0], 1'b1, se, p0);
      ed[31:16] = lane_op(x[31:16], y[31:16], 1'b1, se, p1);
      eso = {o1, o0}; edo = {p1, p0};
    end else begin
      es = word_op(x, y, 1'b0, se, o0);
      ed = word_op(x, y, 1'b1, se, p0);
      eso = {1'b0, o0}; edo = {1'b0, p0};
    end
    @(negedge clk);
    cmp(req, "sum", sum_q, es);
    cmp(req, "diff", diff_q, ed);
    cmp(req, "sum_ovf", {30'd0, sum_ovf_q}, {30'd0, eso});
    cmp(req, "diff_ovf", {30'd0, diff_ovf_q}, {30'd0, edo});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] sd;
    a = 32'hFFFF_FFFF; b = 32'h1234_5678; dual_mode = 1'b1; sat_en = 1'b1;
    repeat (3) @(negedge clk);
    // R2: outputs held at zero during reset
    cmp("R2", "sum", sum_q, 32'd0);
    cmp("R2", "diff", diff_q, 32'd0);
    cmp("R2", "flags", {28'd0, sum_ovf_q, diff_ovf_q}, 32'd0);
    rst_n = 1'b1;

    // R1/R3: basic word wrap and routing
    run(32'd100, 32'd30, 1'b0, 1'b0, "R1");
    run(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R3");
    // R5/R7/R8: word overflow, both directions, sat on and off
    run(32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, "R5");
    run(32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1, "R7");
    run(32'h8000_0000, 32'd1, 1'b0, 1'b1, "R7");
    run(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0, "R8");
    run(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, "R7");
    // R4: no carry between lanes
    run(32'h0000_FFFF, 32'h0000_0001, 1'b1, 1'b0, "R4");
    run(32'h0001_0000, 32'h0000_0001, 1'b1, 1'b0, "R4");
    // R6/R7/R8: lane overflow in each lane separately
    run(32'h0000_7FFF, 32'h0000_0001, 1'b1, 1'b1, "R6");
    run(32'h8000_0000, 32'h0001_0000, 1'b1, 1'b1, "R6");
    run(32'h7FFF_8000, 32'h8000_7FFF, 1'b1, 1'b0, "R8");
    run(32'h7FFF_8000, 32'h8000_7FFF, 1'b1, 1'b1, "R7");
    // R9: sat_en with in-range operands
    run(32'h1234_5678, 32'h0101_0101, 1'b0, 1'b1, "R9");
    run(32'h1234_5678, 32'h0101_0101, 1'b1, 1'b1, "R9");

    sd = 32'd0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = $urandom(); y = $urandom();
      if (i % 5 == 0) x[30:16] = {15{x[31]}};
      run(x, y, i[0], i[1], i[0] ? "R4" : "R3");
    end

    // R2: reset in the middle clears
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    cmp("R2", "sum after reset", sum_q, 32'd0);
    cmp("R2", "diff after reset", diff_q, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule